// File: doc/BRIEF.md
# Dual-Table Trace Readout Sequencer

This block replays two stored waveform tables, A and B, as a stream of display samples for a swept screen. Each table holds 512 eight-bit values. Each sample carries a 10-bit horizontal position, an 8-bit vertical value, a trace identifier, a valid strobe and an end-of-trace flag. A single-cycle `step` pulse asks for the next sample, so the caller sets the pace of the sweep. Both tables are on-chip synchronous RAMs with one write port for loading.

Table B sits half a step to the right of table A. A's entry i is drawn at position 2i and B's entry i at position 2i+1. Four display selections are offered: A alone, B alone, both tables, and B minus A. When both tables are selected, the `save_a` input picks one of two layouts. Either the tables are drawn as two separate traces, or they are merged into one interlaced trace of 1024 points. The selection is taken at the first sample of every trace and is then held until that trace's last sample.

Top module: `trace_readout`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `smp_valid` and `smp_last` are 0. The first trace after reset starts at its first position.
- R2: Each `step` pulse produces exactly one sample, with `smp_valid` high two clock edges after the edge that sampled `step`. No sample appears without a `step`.
- R3: With `disp_sel`=0 (A only), a trace is 512 samples: sample i has X=2i, Y=A[i] and `smp_trace`=0.
- R4: With `disp_sel`=1 (B only), a trace is 512 samples: sample i has X=2i+1, Y=B[i] and `smp_trace`=1.
- R5: With `disp_sel`=2 and `save_a`=1, the block draws a 512-sample A trace (id 0, X=2i) and then a 512-sample B trace (id 1, X=2i+1), if the selection still holds when the B trace starts.
- R6: With `disp_sel`=2 and `save_a`=0, a trace is 1024 samples with X=k and id 2. Y is A[k/2] for even k and B[(k-1)/2] for odd k.
- R7: With `disp_sel`=3 (difference), a trace is 512 samples with X=2i and id 3. Y is B[i]-A[i]+128, clamped to the range 0..255.
- R8: `smp_last` is high on the final sample of each trace and on no other sample. That is X=1022 for ids 0 and 3, and X=1023 for ids 1 and 2.
- R9: Changes to `disp_sel` or `save_a` during a trace do not change that trace. They take effect at the next trace.
- R10: A write with `wr_en`=1 stores `wr_data` at `wr_addr` in table A when `wr_sel`=0, or in table B when `wr_sel`=1. Later traces read the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Write target: 0 = table A, 1 = table B |
| wr_addr | input | 9 | Table entry to write |
| wr_data | input | 8 | Value to write |
| step | input | 1 | Request for the next sample |
| disp_sel | input | 2 | Display selection: 0 A, 1 B, 2 both, 3 difference |
| save_a | input | 1 | With both tables: 1 = separate traces, 0 = interlaced |
| smp_valid | output | 1 | Sample strobe |
| smp_x | output | 10 | Horizontal position |
| smp_y | output | 8 | Vertical value |
| smp_trace | output | 2 | Trace id: 0 A, 1 B, 2 interlaced, 3 difference |
| smp_last | output | 1 | Final sample of the current trace |

## Verification
A wrong position counter or a wrong latched selection shows at the ports on the very next sample. It appears as an X that breaks the stride of 2 (or 1 when interlaced), as an X with the wrong parity for its trace id, or as a trace id that changes in the middle of a trace. A wrong read index or a bad difference path changes only Y. Every sample is compared against a model two edges after its `step`, so such an error is caught on the first affected point. A lost pair state or a misplaced end-of-trace flag shows up within one trace length, as a wrong id or a wrong `smp_last` at the trace boundary.

// File: rtl/trs_pkg.sv
package trs_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_BOTH = 2'd2,
    SEL_DIFF = 2'd3
  } disp_sel_e;

  typedef enum logic [1:0] {
    TR_A      = 2'd0,
    TR_B      = 2'd1,
    TR_MERGED = 2'd2,
    TR_DIFF   = 2'd3
  } trace_kind_e;

endpackage

// File: rtl/trs_table_ram.sv
module trs_table_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trs_seq.sv
module trs_seq
  import trs_pkg::*;
#(
  parameter int AW = 9,
  parameter int XW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [1:0]    disp_sel,
  input  logic          save_a,
  output logic [AW-1:0] rd_idx,
  output logic          m_vld,
  output logic [XW-1:0] m_x,
  output logic [1:0]    m_kind,
  output logic          m_last
);
  localparam logic [AW-1:0] IDX_LAST = {AW{1'b1}};
  localparam logic [XW-1:0] X_LAST   = {XW{1'b1}};

  disp_sel_e   sel;
  trace_kind_e cur_kind, new_kind, eff_kind;
  logic        active, cur_pair, new_pair, pair_b_due;
  logic [XW-1:0] pos, eff_pos, iss_x;
  logic        is_last;

  assign sel = disp_sel_e'(disp_sel);

  // selection sampled only when a trace begins
  always_comb begin
    new_pair = 1'b0;
    unique case (sel)
      SEL_A: new_kind = TR_A;
      SEL_B: new_kind = TR_B;
      SEL_BOTH: begin
        if (save_a) begin
          new_kind = pair_b_due ? TR_B : TR_A;
          new_pair = !pair_b_due;
        end else begin
          new_kind = TR_MERGED;
        end
      end
      default: new_kind = TR_DIFF;
    endcase
  end

  assign eff_kind = active ? cur_kind : new_kind;
  assign eff_pos  = active ? pos : '0;

  always_comb begin
    if (eff_kind == TR_MERGED) begin
      rd_idx  = eff_pos[XW-1:1];
      iss_x   = eff_pos;
      is_last = (eff_pos == X_LAST);
    end else begin
      rd_idx  = eff_pos[AW-1:0];
      iss_x   = {eff_pos[AW-1:0], (eff_kind == TR_B)};
      is_last = (eff_pos[AW-1:0] == IDX_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      cur_kind   <= TR_A;
      cur_pair   <= 1'b0;
      pair_b_due <= 1'b0;
      pos        <= '0;
    end else if (step) begin
      if (!active) begin
        active     <= 1'b1;
        cur_kind   <= new_kind;
        cur_pair   <= new_pair;
        pair_b_due <= 1'b0;
      end
      if (is_last) begin
        active     <= 1'b0;
        pair_b_due <= active ? cur_pair : new_pair;
        pos        <= '0;
      end else begin
        pos <= eff_pos + 1'b1;
      end
    end
  end

  // metadata stage, aligned with the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      m_vld  <= 1'b0;
      m_last <= 1'b0;
      m_x    <= '0;
      m_kind <= '0;
    end else begin
      m_vld  <= step;
      m_last <= step && is_last;
      if (step) begin
        m_x    <= iss_x;
        m_kind <= eff_kind;
      end
    end
  end
endmodule

// File: rtl/trs_yfmt.sv
module trs_yfmt
  import trs_pkg::*;
#(
  parameter int DW = 8,
  parameter int XW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_vld,
  input  logic [XW-1:0] m_x,
  input  logic [1:0]    m_kind,
  input  logic          m_last,
  input  logic [DW-1:0] a_dat,
  input  logic [DW-1:0] b_dat,
  output logic          smp_valid,
  output logic [XW-1:0] smp_x,
  output logic [DW-1:0] smp_y,
  output logic [1:0]    smp_trace,
  output logic          smp_last
);
  localparam int SW = DW + 2;
  localparam logic [SW-1:0] MID = SW'(1 << (DW - 1));

  trace_kind_e   kind;
  logic signed [SW-1:0] dsum;
  logic [DW-1:0] dsat, ysel;

  assign kind = trace_kind_e'(m_kind);

  always_comb begin
    dsum = $signed({2'b00, b_dat}) - $signed({2'b00, a_dat}) + $signed(MID);
    if (dsum[SW-1])      dsat = '0;
    else if (dsum[DW])   dsat = {DW{1'b1}};
    else                 dsat = dsum[DW-1:0];
  end

  always_comb begin
    unique case (kind)
      TR_A:      ysel = a_dat;
      TR_B:      ysel = b_dat;
      TR_MERGED: ysel = m_x[0] ? b_dat : a_dat;
      default:   ysel = dsat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_last  <= 1'b0;
      smp_x     <= '0;
      smp_y     <= '0;
      smp_trace <= '0;
    end else begin
      smp_valid <= m_vld;
      smp_last  <= m_last;
      if (m_vld) begin
        smp_x     <= m_x;
        smp_y     <= ysel;
        smp_trace <= m_kind;
      end
    end
  end
endmodule

// File: rtl/trace_readout.sv
module trace_readout #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int X_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic [1:0]        disp_sel,
  input  logic              save_a,
  output logic              smp_valid,
  output logic [X_W-1:0]    smp_x,
  output logic [DATA_W-1:0] smp_y,
  output logic [1:0]        smp_trace,
  output logic              smp_last
);
  logic [ADDR_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_dat [2];
  logic              m_vld, m_last;
  logic [X_W-1:0]    m_x;
  logic [1:0]        m_kind;

  for (genvar t = 0; t < 2; t++) begin : g_tab
    trs_table_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (wr_en && (wr_sel == 1'(t))),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_idx),
      .rdata (rd_dat[t])
    );
  end

  trs_seq #(.AW(ADDR_W), .XW(X_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .disp_sel (disp_sel),
    .save_a   (save_a),
    .rd_idx   (rd_idx),
    .m_vld    (m_vld),
    .m_x      (m_x),
    .m_kind   (m_kind),
    .m_last   (m_last)
  );

  trs_yfmt #(.DW(DATA_W), .XW(X_W)) u_yfmt (
    .clk       (clk),
    .rst       (rst),
    .m_vld     (m_vld),
    .m_x       (m_x),
    .m_kind    (m_kind),
    .m_last    (m_last),
    .a_dat     (rd_dat[0]),
    .b_dat     (rd_dat[1]),
    .smp_valid (smp_valid),
    .smp_x     (smp_x),
    .smp_y     (smp_y),
    .smp_trace (smp_trace),
    .smp_last  (smp_last)
  );
endmodule

// File: rtl/trs_chk.sv
module trs_chk #(
  parameter int XW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic          smp_valid,
  input logic [XW-1:0] smp_x,
  input logic [1:0]    smp_trace,
  input logic          smp_last
);
  localparam logic [XW-1:0] X_END_ODD  = {XW{1'b1}};
  localparam logic [XW-1:0] X_END_EVEN = {{(XW-1){1'b1}}, 1'b0};

  logic [1:0]    cyc;
  logic          mid;
  logic [XW-1:0] prev_x;
  logic [1:0]    prev_tr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= '0;
      mid     <= 1'b0;
      prev_x  <= '0;
      prev_tr <= '0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      if (smp_valid) begin
        mid     <= !smp_last;
        prev_x  <= smp_x;
        prev_tr <= smp_trace;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !smp_valid && !smp_last);

  // R2
  step_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (smp_valid == $past(step, 2)));

  // R3
  a_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && (smp_trace == 2'd0 || smp_trace == 2'd3)) |-> !smp_x[0]);

  // R4
  b_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_trace == 2'd1) |-> smp_x[0]);

  // R8
  last_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_last) |->
      (smp_x == ((smp_trace == 2'd0 || smp_trace == 2'd3) ? X_END_EVEN : X_END_ODD)));

  // R9
  trace_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mid) |-> (smp_trace == prev_tr));

  // R6
  x_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mid) |->
      (smp_x == prev_x + ((smp_trace == 2'd2) ? XW'(1) : XW'(2))));

  // R1
  first_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !mid) |-> (smp_x[XW-1:1] == '0));
endmodule

bind trace_readout trs_chk #(.XW(X_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .smp_valid (smp_valid),
  .smp_x     (smp_x),
  .smp_trace (smp_trace),
  .smp_last  (smp_last)
);

// File: tb/sim_trace_readout.sv
`timescale 1ns/1ps
module sim_trace_readout;
  typedef struct {
    bit v;
    bit last;
    int x;
    int y;
    int id;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       step = 1'b0;
  logic [1:0] disp_sel = 2'd0;
  logic       save_a = 1'b0;
  logic       smp_valid, smp_last;
  logic [9:0] smp_x;
  logic [7:0] smp_y;
  logic [1:0] smp_trace;

  int   checks = 0, fails = 0;
  bit   done = 0;
  string phase = "R1 reset";

  int   ta [512];
  int   tb [512];
  exp_t tq [$];
  exp_t d1, d2, nxt;
  bit   due_b = 0;

  always #2.5 clk = ~clk;

  trace_readout u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .step(step), .disp_sel(disp_sel), .save_a(save_a),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_trace(smp_trace), .smp_last(smp_last)
  );

  function automatic int clampd(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic push_half(int id);
    for (int i = 0; i < 512; i++) begin
      exp_t e;
      e.v = 1; e.last = (i == 511); e.id = id;
      e.x = (id == 1) ? 2*i + 1 : 2*i;
      if (id == 0)      e.y = ta[i];
      else if (id == 1) e.y = tb[i];
      else              e.y = clampd(tb[i] - ta[i] + 128);
      tq.push_back(e);
    end
  endtask

  task automatic build_trace();
    bit nb = 0;
    case (disp_sel)
      2'd0: push_half(0);
      2'd1: push_half(1);
      2'd2: begin
        if (save_a) begin
          if (due_b) push_half(1);
          else begin push_half(0); nb = 1; end
        end else begin
          for (int k = 0; k < 1024; k++) begin
            exp_t e;
            e.v = 1; e.last = (k == 1023); e.id = 2; e.x = k;
            e.y = (k % 2 == 1) ? tb[k/2] : ta[k/2];
            tq.push_back(e);
          end
        end
      end
      default: push_half(3);
    endcase
    due_b = nb;
  endtask

  // reference model, two edges from step to sample
  always @(posedge clk) begin
    if (rst) begin
      d1 <= '{0, 0, 0, 0, 0};
      d2 <= '{0, 0, 0, 0, 0};
      tq.delete();
      due_b = 0;
    end else begin
      nxt = '{0, 0, 0, 0, 0};
      if (step) begin
        if (tq.size() == 0) build_trace();
        nxt = tq.pop_front();
      end
      d1 <= nxt;
      d2 <= d1;
    end
  end

  function automatic string id_req(int id);
    case (id)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rst) begin
        if (smp_valid !== 1'b0 || smp_last !== 1'b0) begin
          fails++;
          $display("FAIL R1 reset: got valid=%0b last=%0b exp valid=0 last=0",
                   smp_valid, smp_last);
        end
      end else if (smp_valid !== d2.v) begin
        fails++;
        $display("FAIL R2 [%s]: got valid=%0b exp valid=%0b", phase, smp_valid, d2.v);
      end else if (d2.v && smp_last !== d2.last) begin
        fails++;
        $display("FAIL R8 [%s]: got last=%0b x=%0d exp last=%0b x=%0d",
                 phase, smp_last, smp_x, d2.last, d2.x);
      end else if (d2.v && (int'(smp_x) != d2.x || int'(smp_y) != d2.y
                            || int'(smp_trace) != d2.id)) begin
        fails++;
        $display("FAIL %s [%s]: got x=%0d y=%0d id=%0d exp x=%0d y=%0d id=%0d",
                 id_req(d2.id), phase, smp_x, smp_y, smp_trace, d2.x, d2.y, d2.id);
      end
    end
  end

  task automatic wr(bit s, int a, int d);
    wr_en = 1; wr_sel = s; wr_addr = 9'(a); wr_data = 8'(d);
    if (s) tb[a] = d; else ta[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step = 1;
      @(negedge clk);
      step = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R10 table load";
    for (int i = 0; i < 512; i++) begin
      wr(0, i, (i*7 + 3) % 256);
      wr(1, i, (i*13 + 200) % 256);
    end
    // difference saturation corners
    wr(0, 0, 255); wr(1, 0, 0);
    wr(0, 1, 0);   wr(1, 1, 255);
    wr(0, 2, 77);  wr(1, 2, 77);
    repeat (2) @(negedge clk);

    phase = "R3 A only";       disp_sel = 2'd0; run(512, 0);
    phase = "R4 B only gaps";  disp_sel = 2'd1; run(512, 1);
    phase = "R5 separate";     disp_sel = 2'd2; save_a = 1; run(1024, 0);
    phase = "R6 interlaced";   save_a = 0; run(1024, 0);
    phase = "R7 difference";   disp_sel = 2'd3; run(512, 2);
    phase = "R9 mid change";   disp_sel = 2'd0; run(100, 0);
    disp_sel = 2'd1; save_a = 1; run(412, 0);
    run(512, 0);
    repeat (3) @(negedge clk);
    phase = "R10 rewrite";
    wr(0, 5, 8'h5A); wr(1, 300, 8'h11);
    disp_sel = 2'd2; save_a = 0; run(1024, 0);
    phase = "R2 idle";
    repeat (6) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no finish exp finish");
      finish_up();
    end
  end
endmodule